// File: doc/BRIEF.md
# Control Register Mode Tracker

This block holds the processor's main control register, the feature control register and the extended-feature enable register, together with a byte of hidden mode flags derived from them. It accepts single-cycle write strobes with new register values, works out whether a paging enable or disable also moves the core into or out of long mode, and keeps the derived flags consistent with the stored registers. Its downstream users are the translation logic, which watches a one-cycle flush pulse, and the fetch logic, which watches a one-cycle pulse asking it to cut the instruction pointer to 32 bits.

It also owns the state of the address line 20 gate. A level request input is compared with the gate bit of the current mask every cycle. When they differ, the mask is reloaded and a flush is raised.

Top module: `ctl_mode_tracker`

## Requirements
- R1: A main control register write whose value differs from the stored one in bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable) raises `tlbFlush` for exactly one cycle, in the cycle after the write is sampled. A write that changes none of these bits raises no flush.
- R2: A main control write that takes bit 31 from 0 to 1 while extended-enable bit 8 (long enable) is set and feature bit 5 (physical address extension) is set enters long mode. Extended bit 10 (long active) and hidden flag bit 5 (long active) are then set.
- R3: A main control write that takes bit 31 from 1 to 0 while extended bit 10 is set leaves long mode. It clears extended bit 10, hidden bit 5 and hidden bit 6 (64-bit code), and raises `ipTrunc` for one cycle. A paging disable with bit 10 clear raises no `ipTrunc`.
- R4: The stored main control value is the written value with bit 4 forced to 1.
- R5: Hidden bit 0 equals stored main control bit 0. Hidden bit 1 (segment base add) is set by every main control write with bit 0 clear, and is otherwise kept.
- R6: Every accepted main control write copies its bits 1, 2 and 3 into hidden bits 2, 3 and 4.
- R7: A feature register write whose stored value differs from the current one in bit 7, bit 5 or bit 4 raises `tlbFlush` for one cycle. Otherwise it raises none.
- R8: When `sseAvail` is low, feature bit 9 is cleared before storing. Hidden bit 7 always equals stored feature bit 9.
- R9: When `a20Req` differs from bit 20 of `a20Mask`, the mask becomes 0xFFEFFFFF ORed with the request at bit 20 and `tlbFlush` pulses. A request equal to the current bit changes nothing and raises no flush.
- R10: After reset the main control register reads 0x60000010 and the hidden flags read 0x02 (segment base add set, real mode). Feature and extended registers read 0, `a20Mask` reads 0xFFFFFFFF, and both pulses are low.
- R11: An extended-enable write stores every bit except bit 10, which keeps its current value.
- R12: `setCode64` sets hidden bit 6 only while hidden bit 5 is set. Otherwise it has no effect.
- R13: A paging enable with long enable set but feature bit 5 clear is discarded: the main control register and hidden flags keep their values. The flush of R1 is still raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrCr0 | input | 1 | Main control register write strobe |
| cr0Data | input | 32 | Main control write value |
| wrCr4 | input | 1 | Feature register write strobe |
| cr4Data | input | 32 | Feature register write value |
| wrEfer | input | 1 | Extended-enable register write strobe |
| eferData | input | 32 | Extended-enable write value |
| setCode64 | input | 1 | Marks the current code segment as 64-bit |
| a20Req | input | 1 | Requested address line 20 gate state (level) |
| sseAvail | input | 1 | Streaming SIMD feature present |
| cr0Q | output | 32 | Stored main control register |
| cr4Q | output | 32 | Stored feature register |
| eferQ | output | 32 | Stored extended-enable register |
| a20Mask | output | 32 | Physical address mask |
| hidFlags | output | 8 | Hidden mode flags |
| ipTrunc | output | 1 | One-cycle instruction pointer truncate pulse |
| tlbFlush | output | 1 | One-cycle translation flush pulse |

## Verification
Every result of a write sampled at one rising edge is due right after that edge. The registers and hidden flags take their new values there, and the two pulses are high for that one cycle only. The bench therefore drives each stimulus on a falling edge and checks all seven outputs on the next falling edge, one full edge later. A directed step then checks the flush pulse again one cycle further on, where it must already be low. Address gate changes follow the same one-edge latency, because the compare happens in the cycle in which the request level is presented.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int REG_W = 32;
  localparam int HID_W = 8;

  // main control register bit positions
  localparam int CR0_PE = 0;
  localparam int CR0_ET = 4;
  localparam int CR0_WP = 16;
  localparam int CR0_PG = 31;
  // feature register bit positions
  localparam int CR4_PSE = 4;
  localparam int CR4_PAE = 5;
  localparam int CR4_PGE = 7;
  localparam int CR4_OSFX = 9;
  // extended-enable register bit positions
  localparam int EFER_LME = 8;
  localparam int EFER_LMA = 10;

  localparam logic [REG_W-1:0] CR0_XLAT_MASK =
    (REG_W'(1) << CR0_PG) | (REG_W'(1) << CR0_WP) | (REG_W'(1) << CR0_PE);
  localparam logic [REG_W-1:0] CR4_XLAT_MASK =
    (REG_W'(1) << CR4_PGE) | (REG_W'(1) << CR4_PAE) | (REG_W'(1) << CR4_PSE);

  typedef struct packed {
    logic osfx;
    logic code64;
    logic longAct;
    logic fpuTs;
    logic fpuEm;
    logic fpuMp;
    logic addSeg;
    logic peMode;
  } hid_t;

  typedef struct packed {
    logic loadCr0;
    logic goLong;
    logic leaveLong;
    logic loadCr4;
    logic loadEfer;
    logic loadA20;
    logic setCs64;
    logic flush;
    logic trunc;
  } strobe_t;

  function automatic logic [REG_W-1:0] cr0Fix(input logic [REG_W-1:0] v);
    return v | (REG_W'(1) << CR0_ET);
  endfunction

  function automatic logic [REG_W-1:0] cr4Fix(input logic [REG_W-1:0] v,
                                              input logic sse);
    return sse ? v : (v & ~(REG_W'(1) << CR4_OSFX));
  endfunction

  function automatic hid_t hidAfterCr0(input hid_t cur, input logic [REG_W-1:0] v);
    hid_t n;
    n = cur;
    n.peMode = v[CR0_PE];
    n.addSeg = cur.addSeg | ~v[CR0_PE];
    n.fpuMp  = v[1];
    n.fpuEm  = v[2];
    n.fpuTs  = v[3];
    return n;
  endfunction
endpackage

// File: rtl/cmt_ctrl.sv
module cmt_ctrl
  import cmt_pkg::*;
(
  input  logic             wrCr0,
  input  logic [REG_W-1:0] cr0Data,
  input  logic             wrCr4,
  input  logic [REG_W-1:0] cr4Data,
  input  logic             wrEfer,
  input  logic             setCode64,
  input  logic             a20Req,
  input  logic             sseAvail,
  input  logic [REG_W-1:0] cr0Cur,
  input  logic [REG_W-1:0] cr4Cur,
  input  logic             lmeOn,
  input  logic             lmaOn,
  input  logic             paeOn,
  input  logic             a20Cur,
  input  logic             longOn,
  output strobe_t          stb
);
  logic [REG_W-1:0] cr0New, cr4New, cr0Diff, cr4Diff;
  logic pgOld, pgNew, enterReq, rejectWr, exitReq, cr0Flush, cr4Flush, a20Chg;

  always_comb begin
    cr0New   = cr0Fix(cr0Data);
    cr4New   = cr4Fix(cr4Data, sseAvail);
    cr0Diff  = (cr0New ^ cr0Cur) & CR0_XLAT_MASK;
    cr4Diff  = (cr4New ^ cr4Cur) & CR4_XLAT_MASK;
    pgOld    = (cr0Cur & (REG_W'(1) << CR0_PG)) != '0;
    pgNew    = (cr0New & (REG_W'(1) << CR0_PG)) != '0;
    cr0Flush = wrCr0 && (cr0Diff != '0);
    cr4Flush = wrCr4 && (cr4Diff != '0);
    enterReq = wrCr0 && !pgOld && pgNew && lmeOn;
    rejectWr = enterReq && !paeOn;
    exitReq  = wrCr0 && pgOld && !pgNew && lmaOn;
    a20Chg   = a20Req != a20Cur;

    stb.loadCr0   = wrCr0 && !rejectWr;
    stb.goLong    = enterReq && !rejectWr;
    stb.leaveLong = exitReq;
    stb.loadCr4   = wrCr4;
    stb.loadEfer  = wrEfer;
    stb.loadA20   = a20Chg;
    stb.setCs64   = setCode64 && longOn;
    stb.flush     = cr0Flush || cr4Flush || a20Chg;
    stb.trunc     = exitReq;
  end
endmodule

// File: rtl/cmt_regs.sv
module cmt_regs
  import cmt_pkg::*;
#(
  parameter int               A20_BIT   = 20,
  parameter logic [REG_W-1:0] RESET_CR0 = 32'h6000_0010
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [REG_W-1:0] cr0Data,
  input  logic [REG_W-1:0] cr4Data,
  input  logic [REG_W-1:0] eferData,
  input  logic             a20Req,
  input  logic             sseAvail,
  output logic [REG_W-1:0] cr0Q,
  output logic [REG_W-1:0] cr4Q,
  output logic [REG_W-1:0] eferQ,
  output logic [REG_W-1:0] a20MaskQ,
  output hid_t             hidQ,
  output logic             flushQ,
  output logic             truncQ
);
  localparam logic [REG_W-1:0] LMA_BIT  = REG_W'(1) << EFER_LMA;
  localparam logic [REG_W-1:0] GATE_BIT = REG_W'(1) << A20_BIT;
  localparam logic [REG_W-1:0] CR0_RST  = cr0Fix(RESET_CR0);

  logic [REG_W-1:0] cr0N, cr4N, eferN, maskN;
  hid_t hidN;

  always_comb begin
    cr0N  = cr0Q;
    cr4N  = cr4Q;
    eferN = eferQ;
    maskN = a20MaskQ;
    hidN  = hidQ;
    if (stb.loadEfer) eferN = (eferData & ~LMA_BIT) | (eferQ & LMA_BIT);
    if (stb.loadCr0) begin
      cr0N = cr0Fix(cr0Data);
      hidN = hidAfterCr0(hidQ, cr0N);
    end
    if (stb.goLong) begin
      eferN = eferN | LMA_BIT;
      hidN.longAct = 1'b1;
    end
    if (stb.setCs64) hidN.code64 = 1'b1;
    if (stb.leaveLong) begin
      eferN = eferN & ~LMA_BIT;
      hidN.longAct = 1'b0;
      hidN.code64  = 1'b0;
    end
    if (stb.loadCr4) begin
      cr4N = cr4Fix(cr4Data, sseAvail);
      hidN.osfx = (cr4N & (REG_W'(1) << CR4_OSFX)) != '0;
    end
    if (stb.loadA20) maskN = ~GATE_BIT | (a20Req ? GATE_BIT : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cr0Q     <= CR0_RST;
      hidQ     <= hidAfterCr0('0, CR0_RST);
      cr4Q     <= '0;
      eferQ    <= '0;
      a20MaskQ <= '1;
      flushQ   <= 1'b0;
      truncQ   <= 1'b0;
    end else begin
      cr0Q     <= cr0N;
      hidQ     <= hidN;
      cr4Q     <= cr4N;
      eferQ    <= eferN;
      a20MaskQ <= maskN;
      flushQ   <= stb.flush;
      truncQ   <= stb.trunc;
    end
  end
endmodule

// File: rtl/ctl_mode_tracker.sv
module ctl_mode_tracker
  import cmt_pkg::*;
#(
  parameter int               A20_BIT   = 20,
  parameter logic [REG_W-1:0] RESET_CR0 = 32'h6000_0010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrCr0,
  input  logic [REG_W-1:0] cr0Data,
  input  logic             wrCr4,
  input  logic [REG_W-1:0] cr4Data,
  input  logic             wrEfer,
  input  logic [REG_W-1:0] eferData,
  input  logic             setCode64,
  input  logic             a20Req,
  input  logic             sseAvail,
  output logic [REG_W-1:0] cr0Q,
  output logic [REG_W-1:0] cr4Q,
  output logic [REG_W-1:0] eferQ,
  output logic [REG_W-1:0] a20Mask,
  output logic [HID_W-1:0] hidFlags,
  output logic             ipTrunc,
  output logic             tlbFlush
);
  strobe_t stb;
  hid_t    hidQ;

  cmt_ctrl ctrl_i (
    .wrCr0(wrCr0), .cr0Data(cr0Data), .wrCr4(wrCr4), .cr4Data(cr4Data),
    .wrEfer(wrEfer), .setCode64(setCode64), .a20Req(a20Req), .sseAvail(sseAvail),
    .cr0Cur(cr0Q), .cr4Cur(cr4Q),
    .lmeOn(eferQ[EFER_LME]), .lmaOn(eferQ[EFER_LMA]), .paeOn(cr4Q[CR4_PAE]),
    .a20Cur(a20Mask[A20_BIT]), .longOn(hidQ.longAct), .stb(stb)
  );

  cmt_regs #(.A20_BIT(A20_BIT), .RESET_CR0(RESET_CR0)) regs_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cr0Data(cr0Data), .cr4Data(cr4Data),
    .eferData(eferData), .a20Req(a20Req), .sseAvail(sseAvail),
    .cr0Q(cr0Q), .cr4Q(cr4Q), .eferQ(eferQ), .a20MaskQ(a20Mask),
    .hidQ(hidQ), .flushQ(tlbFlush), .truncQ(ipTrunc)
  );

  assign hidFlags = hidQ;
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker (
  input logic clk,
  input logic rstN,
  input logic wrCr4,
  input logic sseAvail,
  input logic peBit,
  input logic osfxBit,
  input logic lmaBit,
  input logic [7:0] hid,
  input logic [31:0] mask,
  input logic ipTrunc
);
  assert_pe_mirror_R5: assert property (@(posedge clk) disable iff (!rstN)
    hid[0] == peBit);
  assert_real_addseg_R5: assert property (@(posedge clk) disable iff (!rstN)
    !peBit |-> hid[1]);
  assert_long_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    hid[5] == lmaBit);
  assert_code64_long_R12: assert property (@(posedge clk) disable iff (!rstN)
    hid[6] |-> hid[5]);
  assert_osfx_mirror_R8: assert property (@(posedge clk) disable iff (!rstN)
    hid[7] == osfxBit);
  assert_osfx_nosse_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrCr4 && !sseAvail) |=> !osfxBit);
  assert_mask_shape_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mask | 32'h0010_0000) == 32'hFFFF_FFFF);
  assert_trunc_exit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ipTrunc |-> !lmaBit);
endmodule

bind ctl_mode_tracker cmt_checker chk_i (
  .clk(clk), .rstN(rstN), .wrCr4(wrCr4), .sseAvail(sseAvail),
  .peBit(cr0Q[0]), .osfxBit(cr4Q[9]), .lmaBit(eferQ[10]),
  .hid(hidFlags), .mask(a20Mask), .ipTrunc(ipTrunc)
);

// File: tb/ctl_mode_tracker_tb_top.sv
module ctl_mode_tracker_tb_top;
  typedef struct packed {
    logic [2:0]  op;    // 0 main, 1 feature, 2 extended, 3 code64, 4 none
    logic [31:0] data;
    logic        sse;
    logic        a20;
    logic [31:0] eCr0;
    logic [31:0] eCr4;
    logic [31:0] eEfer;
    logic [31:0] eMask;
    logic [7:0]  eHid;
    logic        eFlush;
    logic        eTrunc;
  } vec_t;

  localparam int NV = 21;
  localparam logic [31:0] M1 = 32'hFFFF_FFFF;
  localparam logic [31:0] M0 = 32'hFFEF_FFFF;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 32'h0000000B, 1'b1, 1'b1, 32'h0000001B, 32'h0,   32'h0,   M1, 8'h17, 1'b1, 1'b0}, // R4 R5 R6 R1
    '{3'd0, 32'h00000004, 1'b1, 1'b1, 32'h00000014, 32'h0,   32'h0,   M1, 8'h0A, 1'b1, 1'b0}, // R6 R5
    '{3'd0, 32'h00000015, 1'b1, 1'b1, 32'h00000015, 32'h0,   32'h0,   M1, 8'h0B, 1'b1, 1'b0}, // R5
    '{3'd0, 32'h00000005, 1'b1, 1'b1, 32'h00000015, 32'h0,   32'h0,   M1, 8'h0B, 1'b0, 1'b0}, // R1 no flush
    '{3'd1, 32'h00000200, 1'b0, 1'b1, 32'h00000015, 32'h0,   32'h0,   M1, 8'h0B, 1'b0, 1'b0}, // R8 R7
    '{3'd1, 32'h00000220, 1'b1, 1'b1, 32'h00000015, 32'h220, 32'h0,   M1, 8'h8B, 1'b1, 1'b0}, // R8 R7
    '{3'd2, 32'h00000100, 1'b1, 1'b1, 32'h00000015, 32'h220, 32'h100, M1, 8'h8B, 1'b0, 1'b0}, // R11
    '{3'd0, 32'h80000011, 1'b1, 1'b1, 32'h80000011, 32'h220, 32'h500, M1, 8'hA3, 1'b1, 1'b0}, // R2
    '{3'd3, 32'h0,        1'b1, 1'b1, 32'h80000011, 32'h220, 32'h500, M1, 8'hE3, 1'b0, 1'b0}, // R12
    '{3'd0, 32'h00000011, 1'b1, 1'b1, 32'h00000011, 32'h220, 32'h100, M1, 8'h83, 1'b1, 1'b1}, // R3
    '{3'd1, 32'h00000200, 1'b1, 1'b1, 32'h00000011, 32'h200, 32'h100, M1, 8'h83, 1'b1, 1'b0}, // R7
    '{3'd0, 32'h80000011, 1'b1, 1'b1, 32'h00000011, 32'h200, 32'h100, M1, 8'h83, 1'b1, 1'b0}, // R13
    '{3'd2, 32'h00000000, 1'b1, 1'b1, 32'h00000011, 32'h200, 32'h0,   M1, 8'h83, 1'b0, 1'b0}, // R11
    '{3'd0, 32'h80010011, 1'b1, 1'b1, 32'h80010011, 32'h200, 32'h0,   M1, 8'h83, 1'b1, 1'b0}, // R1
    '{3'd0, 32'h80010011, 1'b1, 1'b1, 32'h80010011, 32'h200, 32'h0,   M1, 8'h83, 1'b0, 1'b0}, // R1
    '{3'd4, 32'h0,        1'b1, 1'b0, 32'h80010011, 32'h200, 32'h0,   M0, 8'h83, 1'b1, 1'b0}, // R9
    '{3'd4, 32'h0,        1'b1, 1'b0, 32'h80010011, 32'h200, 32'h0,   M0, 8'h83, 1'b0, 1'b0}, // R9 same
    '{3'd4, 32'h0,        1'b1, 1'b1, 32'h80010011, 32'h200, 32'h0,   M1, 8'h83, 1'b1, 1'b0}, // R9
    '{3'd0, 32'h00010010, 1'b1, 1'b1, 32'h00010010, 32'h200, 32'h0,   M1, 8'h82, 1'b1, 1'b0}, // R3 no trunc
    '{3'd2, 32'h00000500, 1'b1, 1'b1, 32'h00010010, 32'h200, 32'h100, M1, 8'h82, 1'b0, 1'b0}, // R11
    '{3'd3, 32'h0,        1'b1, 1'b1, 32'h00010010, 32'h200, 32'h100, M1, 8'h82, 1'b0, 1'b0}  // R12
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrCr0 = 1'b0, wrCr4 = 1'b0, wrEfer = 1'b0, setCode64 = 1'b0;
  logic a20Req = 1'b1, sseAvail = 1'b1;
  logic [31:0] cr0Data = '0, cr4Data = '0, eferData = '0;
  logic [31:0] cr0Q, cr4Q, eferQ, a20Mask;
  logic [7:0]  hidFlags;
  logic        ipTrunc, tlbFlush;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctl_mode_tracker dut_i (
    .clk(clk), .rstN(rstN), .wrCr0(wrCr0), .cr0Data(cr0Data), .wrCr4(wrCr4),
    .cr4Data(cr4Data), .wrEfer(wrEfer), .eferData(eferData), .setCode64(setCode64),
    .a20Req(a20Req), .sseAvail(sseAvail), .cr0Q(cr0Q), .cr4Q(cr4Q), .eferQ(eferQ),
    .a20Mask(a20Mask), .hidFlags(hidFlags), .ipTrunc(ipTrunc), .tlbFlush(tlbFlush)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic checkReset();
    check("R10", "cr0", cr0Q, 32'h60000010);
    check("R10", "cr4", cr4Q, 32'h0);
    check("R10", "efer", eferQ, 32'h0);
    check("R10", "mask", a20Mask, 32'hFFFFFFFF);
    check("R10", "hid", {24'h0, hidFlags}, 32'h02);
    check("R10", "flush", {31'h0, tlbFlush}, 32'h0);
    check("R10", "trunc", {31'h0, ipTrunc}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();  // R10

    for (int i = 0; i < NV; i++) begin
      wrCr0     = (TBL[i].op == 3'd0);
      wrCr4     = (TBL[i].op == 3'd1);
      wrEfer    = (TBL[i].op == 3'd2);
      setCode64 = (TBL[i].op == 3'd3);
      cr0Data   = TBL[i].data;
      cr4Data   = TBL[i].data;
      eferData  = TBL[i].data;
      sseAvail  = TBL[i].sse;
      a20Req    = TBL[i].a20;
      @(negedge clk);
      wrCr0 = 1'b0; wrCr4 = 1'b0; wrEfer = 1'b0; setCode64 = 1'b0;
      check("R4",  $sformatf("v%0d cr0", i),   cr0Q,    TBL[i].eCr0);
      check("R8",  $sformatf("v%0d cr4", i),   cr4Q,    TBL[i].eCr4);
      check("R2",  $sformatf("v%0d efer", i),  eferQ,   TBL[i].eEfer);
      check("R9",  $sformatf("v%0d mask", i),  a20Mask, TBL[i].eMask);
      check("R5",  $sformatf("v%0d hid", i),   {24'h0, hidFlags}, {24'h0, TBL[i].eHid});
      check("R1",  $sformatf("v%0d flush", i), {31'h0, tlbFlush}, {31'h0, TBL[i].eFlush});
      check("R3",  $sformatf("v%0d trunc", i), {31'h0, ipTrunc},  {31'h0, TBL[i].eTrunc});
    end

    // R1: the flush pulse lasts exactly one cycle
    wrCr0 = 1'b1; cr0Data = 32'h00000011;
    @(negedge clk);
    wrCr0 = 1'b0;
    check("R1", "pulse high", {31'h0, tlbFlush}, 32'h1);
    @(negedge clk);
    check("R1", "pulse gone", {31'h0, tlbFlush}, 32'h0);
    check("R6", "fpu bits clear", {24'h0, hidFlags}, 32'h83);

    // R10: reset mid-run restores the power-on values
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkReset();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule